// File: doc/BRIEF.md
# Line Fill Bus Controller

This block sits between a cache and the external memory bus and turns a read miss into a bus read. When the cache hands over a request, the block starts an address phase on the bus. It raises a cacheable-request indication only when the access may be cached and is neither a locked read nor a page-table read. The system answers with an active-low cache-enable input, and the block samples it on the first ready of the data phase. That single sample decides the length of the read: a four-beat 32-byte line burst, or one transfer that the cache must not allocate.

During a burst that evicts a dirty line, the block reads the victim line out of the cache one beat per incoming ready. It stores those beats in a local copyback buffer while the new line arrives. Once the fill is done, it drains the buffer with a four-beat write burst, and only then accepts the next miss. Each received beat goes to the cache with its index inside the line. A done strobe marks the last beat and carries two flags: one says "do not allocate", the other gives the write-back/write-through policy that was sampled on the first ready.

Top module: `linefill_bus_ctrl`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `bus_ads`, `bus_write`, `bus_cache_req` and `fill_valid` are 0.
- R2: `bus_cache_req` equals `req_cacheable & ~req_locked` of the accepted request. It is held through the address phase and the read data phase, and it is 0 in idle and during the write-back.
- R3: Each bus cycle starts with `bus_ads` high for exactly one cycle. For a read, the address is the 32-byte line base (address bits 4:0 cleared) when a cacheable request is made, and the 8-byte beat address (bits 2:0 cleared) otherwise. For the write-back, the address is the line base of `victim_addr`.
- R4: The transfer is a burst only if `bus_cache_req` is 1 and `bus_ken_n` is 0 on the first ready of the read. The value of `bus_ken_n` on later readies has no effect.
- R5: A single transfer finishes on its first ready. On that ready, `fill_valid`, `fill_done` and `fill_noalloc` are all 1. `fill_idx` is request address bits 4:3 when no cacheable request was made, and 0 when one was made.
- R6: A burst delivers exactly four beats, one per ready, with `fill_idx` running 0, 1, 2, 3. `fill_data` equals `bus_rdata`. `fill_done` is 1 on the fourth beat and `fill_noalloc` is 0.
- R7: While `fill_done` is 1, `fill_wb` equals the `bus_wb_wt` value sampled on the first ready of that read.
- R8: During a burst with `victim_dirty` set, `victim_idx` shows the current beat and `victim_data` is captured on each ready. After the fill, a write cycle (`bus_write` = 1) sends the four captured beats on `bus_wdata` in index order, one per ready. `req_ready` stays 0 until that cycle ends.
- R9: A dirty victim of a single transfer causes no write cycle, and the block returns to idle right after the read.
- R10: Nothing advances without `bus_rdy` during a data phase. `bus_rdy` is ignored in idle and in the address phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request strobe |
| req_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | AW | Miss address |
| req_cacheable | input | 1 | Access may be cached |
| req_locked | input | 1 | Locked or page-table read |
| victim_dirty | input | 1 | Line to be replaced is modified |
| victim_addr | input | AW | Address of the replaced line |
| victim_idx | output | IW | Victim beat the cache must present |
| victim_data | input | DW | Victim beat data |
| bus_ads | output | 1 | Address strobe |
| bus_write | output | 1 | Current bus cycle is a write |
| bus_addr | output | AW | Bus address |
| bus_cache_req | output | 1 | Cacheable request indication |
| bus_rdy | input | 1 | Beat ready from the system |
| bus_ken_n | input | 1 | Active-low cache enable |
| bus_wb_wt | input | 1 | 1 = write-back, 0 = write-through |
| bus_rdata | input | DW | Read data |
| bus_wdata | output | DW | Write-back data |
| fill_valid | output | 1 | Fill beat valid |
| fill_idx | output | IW | Beat index inside the line |
| fill_data | output | DW | Fill beat data |
| fill_done | output | 1 | Last beat of the read |
| fill_noalloc | output | 1 | With done: do not allocate the line |
| fill_wb | output | 1 | With done: line policy is write-back |

## Verification
The bench uses the default parameters: 32-bit addresses, a 64-bit data bus and four beats per line, which gives 32-byte lines with the beat index in address bits 4:3. At this size the whole burst, including both wait states and the drain of a full copyback buffer, completes in a short run. Randomised ready gaps and randomised enable and policy values on the non-first beats therefore cover the first-ready sampling point and every beat boundary many times over.

// File: rtl/lf_pkg.sv
package lf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RADDR,
    ST_RDATA,
    ST_WADDR,
    ST_WDATA
  } lf_state_e;
endpackage

// File: rtl/lf_beat_ctr.sv
module lf_beat_ctr #(
  parameter int BEATS = 4,
  localparam int IW = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [IW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == IW'(BEATS - 1));
endmodule

// File: rtl/lf_copyback_buf.sv
module lf_copyback_buf #(
  parameter int DW    = 64,
  parameter int BEATS = 4,
  localparam int IW = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == IW'(g)) slot[g] <= wdata;
    end
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/linefill_bus_ctrl.sv
module linefill_bus_ctrl
  import lf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEATS = 4,
  localparam int IW = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_cacheable,
  input  logic          req_locked,
  input  logic          victim_dirty,
  input  logic [AW-1:0] victim_addr,
  output logic [IW-1:0] victim_idx,
  input  logic [DW-1:0] victim_data,
  output logic          bus_ads,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_cache_req,
  input  logic          bus_rdy,
  input  logic          bus_ken_n,
  input  logic          bus_wb_wt,
  input  logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] bus_wdata,
  output logic          fill_valid,
  output logic [IW-1:0] fill_idx,
  output logic [DW-1:0] fill_data,
  output logic          fill_done,
  output logic          fill_noalloc,
  output logic          fill_wb
);
  localparam int BYTEW = $clog2(DW / 8);
  localparam int OFFW  = BYTEW + IW;

  function automatic logic [AW-1:0] line_base(input logic [AW-1:0] a);
    return {a[AW-1:OFFW], {OFFW{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] beat_base(input logic [AW-1:0] a);
    return {a[AW-1:BYTEW], {BYTEW{1'b0}}};
  endfunction

  function automatic logic [IW-1:0] beat_of(input logic [AW-1:0] a);
    return a[OFFW-1:BYTEW];
  endfunction

  lf_state_e     state, state_nx;
  logic [AW-1:0] addr_q, vaddr_q;
  logic          creq_q, dirty_q, burst_q, wb_q;
  logic [IW-1:0] cnt;
  logic          cnt_last;
  logic [DW-1:0] cb_rdata;

  // named internal events
  logic in_rd, in_wr, first_beat, ken_ok, burst_now;
  logic ev_accept, ev_rd_beat, ev_rd_last, ev_wr_beat, ev_wr_last, cb_we;

  assign in_rd      = (state == ST_RDATA);
  assign in_wr      = (state == ST_WDATA);
  assign first_beat = (cnt == '0);
  assign ken_ok     = creq_q & ~bus_ken_n;
  assign burst_now  = first_beat ? ken_ok : burst_q;
  assign ev_accept  = req_valid & req_ready;
  assign ev_rd_beat = in_rd & bus_rdy;
  assign ev_rd_last = ev_rd_beat & (~burst_now | cnt_last);
  assign ev_wr_beat = in_wr & bus_rdy;
  assign ev_wr_last = ev_wr_beat & cnt_last;
  assign cb_we      = ev_rd_beat & burst_now & dirty_q;

  lf_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ev_rd_last | ev_wr_last),
    .inc  (ev_rd_beat | ev_wr_beat),
    .cnt  (cnt),
    .last (cnt_last)
  );

  lf_copyback_buf #(.DW(DW), .BEATS(BEATS)) u_cbuf (
    .clk  (clk),
    .we   (cb_we),
    .widx (cnt),
    .wdata(victim_data),
    .ridx (cnt),
    .rdata(cb_rdata)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (ev_accept) state_nx = ST_RADDR;
      ST_RADDR: state_nx = ST_RDATA;
      ST_RDATA: if (ev_rd_last) state_nx = (burst_now && dirty_q) ? ST_WADDR : ST_IDLE;
      ST_WADDR: state_nx = ST_WDATA;
      ST_WDATA: if (ev_wr_last) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      vaddr_q <= '0;
      creq_q  <= 1'b0;
      dirty_q <= 1'b0;
      burst_q <= 1'b0;
      wb_q    <= 1'b0;
    end else begin
      state <= state_nx;
      if (ev_accept) begin
        addr_q  <= req_addr;
        vaddr_q <= victim_addr;
        creq_q  <= req_cacheable & ~req_locked;
        dirty_q <= victim_dirty;
      end
      if (ev_rd_beat && first_beat) begin
        burst_q <= ken_ok;
        wb_q    <= bus_wb_wt;
      end
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign bus_ads       = (state == ST_RADDR) || (state == ST_WADDR);
  assign bus_write     = (state == ST_WADDR) || in_wr;
  assign bus_cache_req = creq_q & ((state == ST_RADDR) || in_rd);
  assign bus_addr      = bus_write ? line_base(vaddr_q)
                       : (creq_q ? line_base(addr_q) : beat_base(addr_q));
  assign bus_wdata     = cb_rdata;
  assign victim_idx    = cnt;
  assign fill_valid    = ev_rd_beat;
  assign fill_idx      = creq_q ? cnt : beat_of(addr_q);
  assign fill_data     = bus_rdata;
  assign fill_done     = ev_rd_last;
  assign fill_noalloc  = ev_rd_last & ~burst_now;
  assign fill_wb       = first_beat ? bus_wb_wt : wb_q;

  logic unused_low_bits;
  assign unused_low_bits = ^{req_addr[BYTEW-1:0], victim_addr[OFFW-1:0]};
endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int BEATS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_locked,
  input logic bus_ads,
  input logic bus_write,
  input logic bus_cache_req,
  input logic bus_rdy,
  input logic fill_valid,
  input logic fill_done,
  input logic fill_noalloc,
  input logic ev_rd_beat,
  input logic burst_now
);
  int unsigned seen;

  always_ff @(posedge clk) begin
    if (!rst_n || fill_done) seen <= 0;
    else if (fill_valid)     seen <= seen + 1;
  end

  AST_LOCK_NO_CACHE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_locked) |=> !bus_cache_req); // R2
  AST_NO_CREQ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> !bus_cache_req); // R2
  AST_ADS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |=> !bus_ads); // R3
  AST_SINGLE_ENDS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_beat && !burst_now) |-> (fill_done && fill_noalloc)); // R5
  AST_BURST_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && !fill_noalloc) |-> (seen == BEATS - 1)); // R6
  AST_NO_ACCEPT_IN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> !req_ready); // R8
  AST_FILL_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> bus_rdy); // R10
endmodule

bind linefill_bus_ctrl lf_checker #(.BEATS(BEATS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_locked   (req_locked),
  .bus_ads      (bus_ads),
  .bus_write    (bus_write),
  .bus_cache_req(bus_cache_req),
  .bus_rdy      (bus_rdy),
  .fill_valid   (fill_valid),
  .fill_done    (fill_done),
  .fill_noalloc (fill_noalloc),
  .ev_rd_beat   (ev_rd_beat),
  .burst_now    (burst_now)
);

// File: tb/sim_linefill_bus_ctrl.sv
module sim_linefill_bus_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_cacheable = 1'b0, req_locked = 1'b0, victim_dirty = 1'b0;
  logic [31:0] req_addr = '0, victim_addr = '0;
  logic [1:0]  victim_idx;
  logic [63:0] victim_data;
  logic        bus_ads, bus_write, bus_cache_req;
  logic [31:0] bus_addr;
  logic        bus_rdy = 1'b0, bus_ken_n = 1'b1, bus_wb_wt = 1'b0;
  logic [63:0] bus_rdata = '0, bus_wdata;
  logic        fill_valid, fill_done, fill_noalloc, fill_wb, req_ready;
  logic [1:0]  fill_idx;
  logic [63:0] fill_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] vtag = 32'hC0DE0000;
  assign victim_data = {vtag, 30'd0, victim_idx};

  linefill_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cacheable(req_cacheable), .req_locked(req_locked),
    .victim_dirty(victim_dirty), .victim_addr(victim_addr), .victim_idx(victim_idx),
    .victim_data(victim_data), .bus_ads(bus_ads), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_cache_req(bus_cache_req), .bus_rdy(bus_rdy),
    .bus_ken_n(bus_ken_n), .bus_wb_wt(bus_wb_wt), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .fill_valid(fill_valid), .fill_idx(fill_idx),
    .fill_data(fill_data), .fill_done(fill_done), .fill_noalloc(fill_noalloc),
    .fill_wb(fill_wb)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 read addr, 2 read data, 3 write addr, 4 write data
  int          m_phase = 0, m_beat = 0;
  logic [31:0] m_addr, m_vaddr;
  bit          m_creq, m_dirty, m_burst, m_wb;
  logic [63:0] m_cbuf[$];
  bit          scen_ken = 1'b1, scen_wb = 1'b0;
  int          ndone = 0;
  bit          last_noalloc, last_wb, saw_wr;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_beat = 0; m_creq = 0; m_dirty = 0;
    end else begin
      bit          e_fv, bd, e_last;
      logic [31:0] e_addr;
      logic [1:0]  e_idx;
      e_fv = 0; bd = 0; e_last = 0;
      chk(req_ready == (m_phase == 0), "R1", "req_ready", 64'(req_ready), 64'(m_phase == 0));
      chk(bus_ads == (m_phase == 1 || m_phase == 3), "R3", "bus_ads", 64'(bus_ads), 64'(m_phase == 1 || m_phase == 3));
      chk(bus_write == (m_phase >= 3), "R8", "bus_write", 64'(bus_write), 64'(m_phase >= 3));
      chk(bus_cache_req == (m_creq && (m_phase == 1 || m_phase == 2)), "R2", "bus_cache_req",
          64'(bus_cache_req), 64'(m_creq && (m_phase == 1 || m_phase == 2)));
      if (m_phase == 1 || m_phase == 3) begin
        e_addr = (m_phase == 3) ? (m_vaddr & ~32'h1F) : (m_creq ? (m_addr & ~32'h1F) : (m_addr & ~32'h7));
        chk(bus_addr == e_addr, "R3", "bus_addr", 64'(bus_addr), 64'(e_addr));
      end
      if (m_phase == 2) begin
        e_fv = bus_rdy;
        bd = (m_beat == 0) ? (m_creq && !bus_ken_n) : m_burst;
        e_last = e_fv && (!bd || m_beat == 3);
        chk(victim_idx == 2'(m_beat), "R8", "victim_idx", 64'(victim_idx), 64'(m_beat));
      end
      chk(fill_valid == e_fv, "R10", "fill_valid", 64'(fill_valid), 64'(e_fv));
      chk(fill_done == e_last, "R6", "fill_done", 64'(fill_done), 64'(e_last));
      if (e_fv) begin
        e_idx = m_creq ? 2'(m_beat) : m_addr[4:3];
        chk(fill_idx == e_idx, "R5", "fill_idx", 64'(fill_idx), 64'(e_idx));
        chk(fill_data == bus_rdata, "R6", "fill_data", fill_data, bus_rdata);
      end
      if (e_last) begin
        chk(fill_noalloc == !bd, "R4", "fill_noalloc", 64'(fill_noalloc), 64'(!bd));
        chk(fill_wb == ((m_beat == 0) ? bus_wb_wt : m_wb), "R7", "fill_wb", 64'(fill_wb),
            64'((m_beat == 0) ? bus_wb_wt : m_wb));
      end
      if (m_phase == 4)
        chk(bus_wdata == m_cbuf[0], "R8", "bus_wdata", bus_wdata, m_cbuf[0]);
      if (fill_done) begin ndone++; last_noalloc = fill_noalloc; last_wb = fill_wb; end
      if (bus_write) saw_wr = 1;
      // advance the model
      case (m_phase)
        0: if (req_valid) begin
             m_addr = req_addr; m_vaddr = victim_addr;
             m_creq = req_cacheable && !req_locked; m_dirty = victim_dirty;
             m_cbuf.delete(); m_phase = 1;
           end
        1: m_phase = 2;
        2: if (bus_rdy) begin
             if (m_beat == 0) begin m_burst = bd; m_wb = bus_wb_wt; end
             if (bd && m_dirty) m_cbuf.push_back({vtag, 30'd0, 2'(m_beat)});
             if (e_last) begin m_phase = (bd && m_dirty) ? 3 : 0; m_beat = 0; end
             else m_beat++;
           end
        3: m_phase = 4;
        4: if (bus_rdy) begin
             void'(m_cbuf.pop_front());
             m_beat++;
             if (m_beat == 4) begin m_beat = 0; m_phase = 0; end
           end
        default: m_phase = 0;
      endcase
    end
  end

  // bus responder: random wait states; enable and policy are random on non-first beats
  always @(posedge clk) begin
    #1;
    if (!rst_n) bus_rdy = 1'b0;
    else begin
      bus_rdy   = ($urandom % 4) != 0;
      bus_rdata = {$urandom, $urandom};
      if (m_phase == 2 && m_beat == 0) begin bus_ken_n = scen_ken; bus_wb_wt = scen_wb; end
      else begin bus_ken_n = 1'($urandom); bus_wb_wt = 1'($urandom); end
    end
  end

  task automatic run_req(input logic [31:0] a, input bit c, input bit l, input bit d,
                         input logic [31:0] va, input bit ken, input bit wb,
                         input bit exp_burst, input bit exp_wr, input string rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_addr = a; req_cacheable = c; req_locked = l; victim_dirty = d; victim_addr = va;
    scen_ken = ken; scen_wb = wb; vtag = vtag + 32'd1;
    ndone = 0; saw_wr = 0; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    #1;
    chk(ndone == 1, rq, "done count", 64'(ndone), 64'd1);
    chk(last_noalloc == !exp_burst, "R4", "burst decision", 64'(last_noalloc), 64'(!exp_burst));
    chk(last_wb == wb, "R7", "policy at done", 64'(last_wb), 64'(wb));
    chk(saw_wr == exp_wr, exp_wr ? "R8" : "R9", "write-back seen", 64'(saw_wr), 64'(exp_wr));
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "reset req_ready", 64'(req_ready), 64'd1);
    chk({bus_ads, bus_write, bus_cache_req, fill_valid} == 4'b0, "R1", "reset outputs",
        64'({bus_ads, bus_write, bus_cache_req, fill_valid}), 64'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    // R5: non-cacheable single transfer, beat 3 of its line
    run_req(32'h1000_0018, 0, 0, 0, 32'h0, 0, 0, 0, 0, "R5");
    // R6: clean cacheable burst, write-back policy
    run_req(32'h2000_0048, 1, 0, 0, 32'h0, 0, 1, 1, 0, "R6");
    // R4: cacheable request refused by cache enable
    run_req(32'h3000_0010, 1, 0, 0, 32'h0, 1, 0, 0, 0, "R4");
    // R2: locked read never requests caching even with enable low
    run_req(32'h4000_0008, 1, 1, 0, 32'h0, 0, 1, 0, 0, "R2");
    // R8: dirty victim on a burst, write-through
    run_req(32'h5000_0000, 1, 0, 1, 32'h7700_0044, 0, 0, 1, 1, "R8");
    // R9: dirty victim on a single transfer
    run_req(32'h6000_0020, 1, 0, 1, 32'h7800_0000, 1, 1, 0, 0, "R9");
    for (int i = 0; i < 40; i++) begin
      bit c, l, d, k, w;
      c = 1'($urandom); l = ($urandom % 4) == 0; d = 1'($urandom);
      k = 1'($urandom); w = 1'($urandom);
      run_req($urandom, c, l, d, $urandom, k, w, c && !l && !k, c && !l && !k && d, "R6");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule